// File: doc/BRIEF.md
# Arcade raster video timing generator

This block produces the complete raster timing for a fixed-resolution arcade video board from a single fast master clock. The master clock passes through a two-stage divider, first by five and then by two. The result is a pixel enable that is high for one master clock in every ten. At the default master rate of 61.44 MHz this gives a pixel rate of 6.144 MHz. Every downstream register runs on the master clock and uses this enable as its clock enable.

A horizontal counter steps once per pixel enable through 384 positions on each scan line. The first 256 positions are visible and the remaining 128 are blanking, which gives a 16 kHz line rate. A vertical counter steps once per line. It does not start at zero: it runs from 248 up to 511 and then reloads 248, which gives 264 lines per frame. The visible window, the blanking and the sync pulses are decoded from that offset range. The frame rate is therefore 6,144,000 / 384 / 264, or about 60.606 Hz, and not an exact 60 Hz.

The outputs are the two counts, the horizontal and vertical blanking and sync levels, the pixel enable, and a single-pulse end-of-frame strobe. Sprite, tile and colour logic sit downstream and consume these outputs.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst_ni is low, and until the internal two-stage release has completed, hcount_o is 0, vcount_o is 248, pix_en_o and frame_end_o are 0, and vblank_o is 1. Assertion of rst_ni takes effect without waiting for a clock edge.
- R2: pix_en_o is high for exactly one master clock in every 10 (divide by 5, then by 2).
- R3: hcount_o changes only in the master clock that follows a pix_en_o pulse. On such a step it goes from n to n+1, and from 383 back to 0, so each line has 384 pixel enables.
- R4: vcount_o steps by one only when hcount_o wraps from 383 to 0. From 511 it reloads 248, never leaves the range 248..511, and each frame has 264 lines.
- R5: hblank_o is 1 exactly when hcount_o is in 256..383. hsync_o (active high) is 1 exactly when hcount_o is in 288..319, so the sync pulse lies inside the blanking interval.
- R6: vblank_o is 1 exactly when vcount_o is below 264 or above 487, leaving 224 visible lines (264..487). vsync_o (active high) is 1 exactly when vcount_o is in 496..503.
- R7: frame_end_o is high for one master clock, only together with pix_en_o, when hcount_o is 383 and vcount_o is 511. On the next clock the counts are 0 and 248.
- R8: Successive frame_end_o pulses are exactly 10 x 384 x 264 = 1,013,760 master clocks apart, which is 60.606 Hz at 61.44 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (61.44 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en_o | output | 1 | One-master-clock pixel enable, once per 10 clocks |
| hcount_o | output | 9 | Horizontal pixel position, 0..383 |
| vcount_o | output | 9 | Vertical line position, 248..511 |
| hblank_o | output | 1 | Horizontal blanking level |
| vblank_o | output | 1 | Vertical blanking level |
| hsync_o | output | 1 | Horizontal sync pulse, active high |
| vsync_o | output | 1 | Vertical sync pulse, active high |
| frame_end_o | output | 1 | Strobe on the last pixel of the last line |

## Verification
The properties take the master clock as the only timing source and treat rst_ni as the only other input. rst_ni may fall at any moment, and every checker counter restarts from that event. The pixel-gap and frame-length properties arm only after their first observed event, so a reset that lands mid-line or mid-frame cannot produce a short interval. The stimulus keeps within these assumptions: it changes rst_ni one time unit after a rising edge, holds each reset for one to four clocks at randomly chosen points, and checks the full 264-line frame on a second instance whose divider ratios are set to one. That keeps the whole frame inside the run length.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;

  // Decoded blanking and sync levels for one raster position.
  typedef struct packed {
    logic hblank;
    logic vblank;
    logic hsync;
    logic vsync;
  } raster_flags_t;

  // Register width for a counter with n states (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/raster_rst_sync.sv
`timescale 1ns/1ps
module raster_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/raster_pix_div.sv
`timescale 1ns/1ps
module raster_pix_div #(
  parameter int PRE_DIV  = 5,
  parameter int POST_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pix_en_o
);

  localparam int PW = raster_pkg::cnt_width(PRE_DIV);
  localparam int QW = raster_pkg::cnt_width(POST_DIV);
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_DIV - 1);
  localparam logic [QW-1:0] POST_LAST = QW'(POST_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [QW-1:0] post_q, post_d;
  logic          mid_tick;

  // First stage wraps every PRE_DIV clocks; its wrap enables the second stage.
  always_comb begin
    mid_tick = (pre_q == PRE_LAST);
    pre_d    = mid_tick ? '0 : pre_q + 1'b1;
    post_d   = post_q;
    if (mid_tick) begin
      post_d = (post_q == POST_LAST) ? '0 : post_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      post_q <= '0;
    end else begin
      pre_q  <= pre_d;
      post_q <= post_d;
    end
  end

  assign pix_en_o = rst_ni && mid_tick && (post_q == POST_LAST);

endmodule

// File: rtl/raster_counter.sv
`timescale 1ns/1ps
module raster_counter #(
  parameter int W     = 9,
  parameter int FIRST = 0,
  parameter int LAST  = 383
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] FIRST_C = W'(FIRST);
  localparam logic [W-1:0] LAST_C  = W'(LAST);

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_last;

  always_comb begin
    at_last = (cnt_q == LAST_C);
    cnt_d   = cnt_q;
    if (en_i) begin
      cnt_d = at_last ? FIRST_C : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= FIRST_C;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i && at_last;

endmodule

// File: rtl/raster_decode.sv
`timescale 1ns/1ps
module raster_decode #(
  parameter int HW          = 9,
  parameter int VW          = 9,
  parameter int H_TOTAL     = 384,
  parameter int H_ACTIVE    = 256,
  parameter int HS_START    = 288,
  parameter int HS_WIDTH    = 32,
  parameter int V_LAST      = 511,
  parameter int V_ACT_START = 264,
  parameter int V_ACT_LINES = 224,
  parameter int VS_START    = 496,
  parameter int VS_WIDTH    = 8
) (
  input  logic                      pix_en_i,
  input  logic [HW-1:0]             hcount_i,
  input  logic [VW-1:0]             vcount_i,
  output raster_pkg::raster_flags_t flags_o,
  output logic                      frame_end_o
);

  localparam logic [HW-1:0] H_ACT_C  = HW'(H_ACTIVE);
  localparam logic [HW-1:0] H_LAST_C = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] HS_LO_C  = HW'(HS_START);
  localparam logic [HW-1:0] HS_HI_C  = HW'(HS_START + HS_WIDTH - 1);
  localparam logic [VW-1:0] VA_LO_C  = VW'(V_ACT_START);
  localparam logic [VW-1:0] VA_HI_C  = VW'(V_ACT_START + V_ACT_LINES - 1);
  localparam logic [VW-1:0] VS_LO_C  = VW'(VS_START);
  localparam logic [VW-1:0] VS_HI_C  = VW'(VS_START + VS_WIDTH - 1);
  localparam logic [VW-1:0] V_LAST_C = VW'(V_LAST);

  always_comb begin
    flags_o.hblank = (hcount_i >= H_ACT_C);
    flags_o.hsync  = (hcount_i >= HS_LO_C) && (hcount_i <= HS_HI_C);
    flags_o.vblank = (vcount_i < VA_LO_C) || (vcount_i > VA_HI_C);
    flags_o.vsync  = (vcount_i >= VS_LO_C) && (vcount_i <= VS_HI_C);
    frame_end_o    = pix_en_i && (hcount_i == H_LAST_C) && (vcount_i == V_LAST_C);
  end

endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen #(
  parameter int PRE_DIV     = 5,
  parameter int POST_DIV    = 2,
  parameter int H_TOTAL     = 384,
  parameter int H_ACTIVE    = 256,
  parameter int HS_START    = 288,
  parameter int HS_WIDTH    = 32,
  parameter int V_FIRST     = 248,
  parameter int V_LINES     = 264,
  parameter int V_ACT_START = 264,
  parameter int V_ACT_LINES = 224,
  parameter int VS_START    = 496,
  parameter int VS_WIDTH    = 8,
  parameter int RST_STAGES  = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  output logic                               pix_en_o,
  output logic [$clog2(H_TOTAL)-1:0]         hcount_o,
  output logic [$clog2(V_FIRST+V_LINES)-1:0] vcount_o,
  output logic                               hblank_o,
  output logic                               vblank_o,
  output logic                               hsync_o,
  output logic                               vsync_o,
  output logic                               frame_end_o
);

  localparam int HW     = $clog2(H_TOTAL);
  localparam int VW     = $clog2(V_FIRST + V_LINES);
  localparam int V_LAST = V_FIRST + V_LINES - 1;

  logic                      rst_sync_n;
  logic                      pix_en;
  logic                      line_wrap;
  logic                      frame_wrap;
  raster_pkg::raster_flags_t flags;

  raster_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  raster_pix_div #(.PRE_DIV(PRE_DIV), .POST_DIV(POST_DIV)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .pix_en_o (pix_en)
  );

  raster_counter #(.W(HW), .FIRST(0), .LAST(H_TOTAL - 1)) u_hcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (pix_en),
    .cnt_o  (hcount_o),
    .wrap_o (line_wrap)
  );

  raster_counter #(.W(VW), .FIRST(V_FIRST), .LAST(V_LAST)) u_vcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (line_wrap),
    .cnt_o  (vcount_o),
    .wrap_o (frame_wrap)
  );

  raster_decode #(
    .HW(HW), .VW(VW), .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE),
    .HS_START(HS_START), .HS_WIDTH(HS_WIDTH), .V_LAST(V_LAST),
    .V_ACT_START(V_ACT_START), .V_ACT_LINES(V_ACT_LINES),
    .VS_START(VS_START), .VS_WIDTH(VS_WIDTH)
  ) u_dec (
    .pix_en_i    (pix_en),
    .hcount_i    (hcount_o),
    .vcount_i    (vcount_o),
    .flags_o     (flags),
    .frame_end_o (frame_end_o)
  );

  assign pix_en_o = pix_en;
  assign hblank_o = flags.hblank;
  assign vblank_o = flags.vblank;
  assign hsync_o  = flags.hsync;
  assign vsync_o  = flags.vsync;

  // The decoder's end-of-frame term and the vertical carry describe the same event.
  logic unused_frame_wrap;
  assign unused_frame_wrap = frame_wrap;

endmodule

// File: rtl/raster_timing_chk.sv
`timescale 1ns/1ps
module raster_timing_chk #(
  parameter int PRE_DIV  = 5,
  parameter int POST_DIV = 2,
  parameter int H_TOTAL  = 384,
  parameter int V_FIRST  = 248,
  parameter int V_LINES  = 264,
  parameter int HW       = 9,
  parameter int VW       = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pix_en_o,
  input logic [HW-1:0] hcount_o,
  input logic [VW-1:0] vcount_o,
  input logic          hblank_o,
  input logic          vblank_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          frame_end_o
);

  localparam logic [31:0]   PIX_GAP   = 32'(PRE_DIV * POST_DIV - 1);
  localparam logic [31:0]   FRAME_GAP = 32'(PRE_DIV * POST_DIV * H_TOTAL * V_LINES - 1);
  localparam logic [HW-1:0] H_LAST_C  = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_FIRST_C = VW'(V_FIRST);
  localparam logic [VW-1:0] V_LAST_C  = VW'(V_FIRST + V_LINES - 1);

  logic [31:0] pix_gap_q, frame_gap_q;
  logic        pix_seen_q, frame_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_gap_q    <= '0;
      frame_gap_q  <= '0;
      pix_seen_q   <= 1'b0;
      frame_seen_q <= 1'b0;
    end else begin
      pix_gap_q   <= pix_en_o ? '0 : pix_gap_q + 1'b1;
      frame_gap_q <= frame_end_o ? '0 : frame_gap_q + 1'b1;
      if (pix_en_o)    pix_seen_q   <= 1'b1;
      if (frame_end_o) frame_seen_q <= 1'b1;
    end
  end

  p_pix_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && pix_seen_q) |-> (pix_gap_q == PIX_GAP));

  p_h_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_o |=> $stable(hcount_o));

  p_h_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && hcount_o != H_LAST_C) |=> (hcount_o == $past(hcount_o) + 1'b1));

  p_h_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && hcount_o == H_LAST_C) |=> (hcount_o == '0));

  p_v_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pix_en_o && hcount_o == H_LAST_C) |=> $stable(vcount_o));

  p_v_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcount_o >= V_FIRST_C) && (vcount_o <= V_LAST_C));

  p_v_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && hcount_o == H_LAST_C && vcount_o == V_LAST_C) |=> (vcount_o == V_FIRST_C));

  p_hsync_in_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> hblank_o);

  p_vsync_in_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> vblank_o);

  p_frame_on_pixel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> (pix_en_o && hcount_o == H_LAST_C && vcount_o == V_LAST_C));

  p_frame_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o);

  p_frame_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_o && frame_seen_q) |-> (frame_gap_q == FRAME_GAP));

endmodule

bind raster_timing_gen raster_timing_chk #(
  .PRE_DIV(PRE_DIV), .POST_DIV(POST_DIV), .H_TOTAL(H_TOTAL),
  .V_FIRST(V_FIRST), .V_LINES(V_LINES), .HW(HW), .VW(VW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_en_o    (pix_en_o),
  .hcount_o    (hcount_o),
  .vcount_o    (vcount_o),
  .hblank_o    (hblank_o),
  .vblank_o    (vblank_o),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .frame_end_o (frame_end_o)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;

  localparam int LINE_PIX  = 384;
  localparam int FRAME_LN  = 264;
  localparam int TIMEOUT   = 195000;

  typedef struct {
    int ph, pv;
    bit ppe, pfe, valid, seen_pe, started;
    int gap, pix_line, lines, pix_frame, clk_frame, frames;
  } mon_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rst_fast_n;
  logic       pe_a, hb_a, vb_a, hs_a, vs_a, fe_a;
  logic [8:0] h_a, v_a;
  logic       pe_b, hb_b, vb_b, hs_b, vs_b, fe_b;
  logic [8:0] h_b, v_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  mon_t mon_a, mon_b;

  raster_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_o(pe_a), .hcount_o(h_a), .vcount_o(v_a),
    .hblank_o(hb_a), .vblank_o(vb_a), .hsync_o(hs_a), .vsync_o(vs_a), .frame_end_o(fe_a)
  );

  // Same raster with both divider stages at one: a whole frame fits the run.
  raster_timing_gen #(.PRE_DIV(1), .POST_DIV(1)) dut_fast_i (
    .clk_i(clk), .rst_ni(rst_fast_n), .pix_en_o(pe_b), .hcount_o(h_b), .vcount_o(v_b),
    .hblank_o(hb_b), .vblank_o(vb_b), .hsync_o(hs_b), .vsync_o(vs_b), .frame_end_o(fe_b)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int nxt_h(input int h);
    return (h == LINE_PIX - 1) ? 0 : h + 1;
  endfunction
  function automatic int nxt_v(input int v, input int h);
    if (h != LINE_PIX - 1) return v;
    return (v == 511) ? 248 : v + 1;
  endfunction
  function automatic int exp_hblank(input int h); return int'(h >= 256); endfunction
  function automatic int exp_hsync(input int h);  return int'(h >= 288 && h <= 319); endfunction
  function automatic int exp_vblank(input int v); return int'(v < 264 || v > 487); endfunction
  function automatic int exp_vsync(input int v);  return int'(v >= 496 && v <= 503); endfunction

  task automatic observe(input string tag, input int div, ref mon_t m, input logic rst,
                         input int h, input int v, input logic pe, input logic hb,
                         input logic vb, input logic hs, input logic vs, input logic fe);
    if (!rst) begin
      chk("R1", {tag, " reset hcount"}, h, 0);
      chk("R1", {tag, " reset vcount"}, v, 248);
      chk("R1", {tag, " reset pix_en"}, int'(pe), 0);
      chk("R1", {tag, " reset frame_end"}, int'(fe), 0);
      chk("R1", {tag, " reset vblank"}, int'(vb), 1);
      m.valid = 0; m.seen_pe = 0; m.started = 0; m.pfe = 0;
      m.gap = 0; m.pix_line = 0; m.lines = 0; m.pix_frame = 0; m.clk_frame = 0;
      return;
    end
    if (m.valid) begin
      chk("R3", {tag, " hcount step"}, h, m.ppe ? nxt_h(m.ph) : m.ph);
      chk("R4", {tag, " vcount step"}, v, m.ppe ? nxt_v(m.pv, m.ph) : m.pv);
      if (m.pfe) begin
        chk("R7", {tag, " hcount after frame end"}, h, 0);
        chk("R7", {tag, " vcount after frame end"}, v, 248);
      end
    end
    m.gap++;
    if (m.started) m.clk_frame++;
    if (pe) begin
      if (m.seen_pe) chk("R2", {tag, " master clocks per pixel"}, m.gap, div);
      m.seen_pe = 1; m.gap = 0;
      if (!m.started) begin m.started = 1; m.clk_frame = div; end
      chk("R5", {tag, " hblank"}, int'(hb), exp_hblank(h));
      chk("R5", {tag, " hsync"}, int'(hs), exp_hsync(h));
      chk("R6", {tag, " vblank"}, int'(vb), exp_vblank(v));
      chk("R6", {tag, " vsync"}, int'(vs), exp_vsync(v));
      chk("R7", {tag, " frame_end on pixel"}, int'(fe), int'(h == 383 && v == 511));
      m.pix_line++; m.pix_frame++;
      if (h == LINE_PIX - 1) begin
        chk("R3", {tag, " pixels per line"}, m.pix_line, LINE_PIX);
        m.pix_line = 0; m.lines++;
      end
      if (fe) begin
        chk("R4", {tag, " lines per frame"}, m.lines, FRAME_LN);
        chk("R8", {tag, " pixels per frame"}, m.pix_frame, LINE_PIX * FRAME_LN);
        chk("R8", {tag, " master clocks per frame"}, m.clk_frame, div * LINE_PIX * FRAME_LN);
        m.lines = 0; m.pix_frame = 0; m.clk_frame = 0; m.frames++;
      end
    end else begin
      chk("R7", {tag, " frame_end without pixel"}, int'(fe), 0);
    end
    m.ph = h; m.pv = v; m.ppe = pe; m.pfe = fe; m.valid = 1;
  endtask

  initial begin
    mon_a = '{default: 0};
    mon_b = '{default: 0};
  end

  always @(negedge clk) begin
    if (!done) begin
      observe("main", 10, mon_a, rst_n, int'(h_a), int'(v_a), pe_a, hb_a, vb_a, hs_a, vs_a, fe_a);
      observe("fast", 1, mon_b, rst_fast_n, int'(h_b), int'(v_b), pe_b, hb_b, vb_b, hs_b, vs_b, fe_b);
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    rst_fast_n = 1'b0;
    void'($urandom(32'd7310));
    fork
      begin : main_branch
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2 * 10 * LINE_PIX + 50);   // two whole lines from reset
        for (int i = 0; i < 6; i++) begin : rand_resets
          wait_clks(int'($urandom_range(6000, 200)));
          rst_n = 1'b0;                      // R1: mid-line asynchronous reset
          wait_clks(int'($urandom_range(4, 1)));
          rst_n = 1'b1;
        end
        wait_clks(5 * 10 * LINE_PIX);
      end
      begin : fast_branch
        wait_clks(3);
        rst_fast_n = 1'b1;
        while (mon_b.frames < 1) wait_clks(1);
        wait_clks(300);
      end
    join
    chk("R8", "fast frame strobes seen", mon_b.frames, 1);
    finish_run();
  end

  initial begin
    repeat (TIMEOUT) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", TIMEOUT);
      finish_run();
    end
  end

endmodule